// File: doc/BRIEF.md
# Linked-List Block Transfer Channel

This block is a bus-mastering transfer engine that walks a chain of command words held in memory and moves bytes between a byte-stream device port and memory buffers without processor help. The processor sets up the chain, hands the engine the address of the first command word with a one-cycle start pulse, and then only hears back once. That happens when the whole chain has finished or when something has gone wrong.

Each command word names a direction, a buffer address, a byte count, a pointer to the next word, and two markers. One marker says the word closes a physical device block. The other says the word ends the chain. In the device-to-memory direction, several consecutive words scatter one device block across buffers that need not be adjacent. In the memory-to-device direction, several words gather scattered buffers into one device block.

The engine has no private memory path. It shares the system bus with the processor and must be granted the bus for every single memory access. It drops its request after each access, so the processor can win arbitration between any two bytes.

Top module: `cwdma_channel`

## Requirements
- R1: A `go` pulse while idle loads `chain_ptr` as the current command word address and raises `busy` on the next cycle. A `go` pulse while `busy` is high has no effect on the running chain.
- R2: A command word is four 32-bit little-endian memory words, fetched with word accesses (`bus_word`=1) at pointer+0, +4, +8 and +12. They hold, in that order: flags, buffer byte address, byte count (low 16 bits used), and next-word pointer. Flag bit 0 set means memory-to-device. Flag bit 1 marks the end of a physical device block. Flag bit 2 marks the end of the chain.
- R3: `bus_req` is high only while `busy` is high. An access completes in a cycle where `bus_req` and `bus_gnt` are both high. `bus_req` is low in the cycle after every completed access. While a request waits for its grant, its address does not change.
- R4: Memory-to-device: the engine reads one byte per byte access (`bus_word`=0, byte in `bus_rdata[7:0]`) from the buffer address upward. It presents the bytes in that order on `dev_out_*`, exactly count bytes per command word. Data is held while `dev_out_ready` is low.
- R5: Device-to-memory: each byte accepted from `dev_in_*` is written (`bus_we`=1, `bus_wdata`) to the next higher buffer address. Exactly count bytes are written per command word, and no byte is written past the buffer end.
- R6: After a word's last byte, the engine fetches the word at the next-word pointer, unless the end-of-chain flag is set.
- R7: `dev_out_last` is high with the final byte of a word whose end-of-block flag is set, and low with every other byte.
- R8: Device-to-memory: `dev_in_last` must be high exactly on the final byte of a word carrying the end-of-block flag. A mismatch stops the chain with an error, and that byte is not written.
- R9: A command word with a zero count stops the chain with an error, and no data byte moves.
- R10: `dev_err` high in any busy cycle stops the chain with an error.
- R11: Each run ends with exactly one single-cycle `irq` pulse, in the cycle `busy` falls. `err` is 1 after an error stop, 0 after a clean finish, and holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse from the processor |
| chain_ptr | input | AW | Address of the first command word |
| busy | output | 1 | Chain in progress |
| err | output | 1 | Last run stopped on an error |
| irq | output | 1 | One-cycle completion/error interrupt |
| bus_req | output | 1 | Bus request for the current access |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_addr | output | AW | Access byte address |
| bus_we | output | 1 | Access is a write |
| bus_word | output | 1 | 1 for 32-bit word read, 0 for byte |
| bus_wdata | output | 8 | Write byte |
| bus_rdata | input | 32 | Read data, same cycle as grant |
| dev_out_valid | output | 1 | Byte offered to the device |
| dev_out_ready | input | 1 | Device takes the byte |
| dev_out_data | output | 8 | Byte to the device |
| dev_out_last | output | 1 | Final byte of a physical block |
| dev_in_valid | input | 1 | Device offers a byte |
| dev_in_ready | output | 1 | Engine takes the byte |
| dev_in_data | input | 8 | Byte from the device |
| dev_in_last | input | 1 | Device marks end of its block |
| dev_err | input | 1 | Device-side error strobe |

## Verification
Suppose the engine loaded a wrong command word field or lost its place in the chain. The ports would show it within one block: bytes arrive from the wrong buffer, a device or memory byte count is off by one, or the end-of-block marker lands on the wrong byte. A broken counter writes the guard byte just past a buffer, and the next memory check catches that. An arbitration fault shows up at once as a request held through the cycle after a grant. A wrong stop path shows up when the interrupt arrives, as a missing, doubled or misflagged pulse.

// File: rtl/cwdma_pkg.sv
package cwdma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_FGAP,
      ST_MRD,
      ST_DOUT,
      ST_DIN,
      ST_MWR,
      ST_NEXT
   } cw_state_t;

   localparam int CW_SLOTS  = 4;
   localparam int FL_TODEV  = 0;
   localparam int FL_EOB    = 1;
   localparam int FL_EOC    = 2;
   localparam int FL_W      = 3;
endpackage

// File: rtl/cwdma_cmd_reg.sv
module cwdma_cmd_reg
   import cwdma_pkg::*;
#(
   parameter int AW   = 32,
   parameter int CNTW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [1:0]      slot,
   input  logic [31:0]     word,
   output logic [FL_W-1:0] flags,
   output logic [AW-1:0]   buf_addr,
   output logic [CNTW-1:0] count,
   output logic [AW-1:0]   next_ptr
);
   logic [31:0] slot_q [CW_SLOTS];

   for (genvar i = 0; i < CW_SLOTS; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q[i] <= '0;
         else if (load && slot == 2'(i))
            slot_q[i] <= word;
      end
   end

   assign flags    = slot_q[0][FL_W-1:0];
   assign buf_addr = slot_q[1][AW-1:0];
   assign count    = slot_q[2][CNTW-1:0];
   assign next_ptr = slot_q[3][AW-1:0];

   logic unused_hi;
   assign unused_hi = ^{slot_q[0][31:FL_W], slot_q[2]};
endmodule

// File: rtl/cwdma_block_ctr.sv
module cwdma_block_ctr #(
   parameter int AW   = 32,
   parameter int CNTW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [AW-1:0]   addr_in,
   input  logic [CNTW-1:0] cnt_in,
   input  logic            step,
   output logic [AW-1:0]   addr,
   output logic [CNTW-1:0] cnt,
   output logic            final_byte
);
   localparam logic [CNTW-1:0] ONE = CNTW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
         cnt  <= '0;
      end else if (load) begin
         addr <= addr_in;
         cnt  <= cnt_in;
      end else if (step) begin
         addr <= addr + AW'(1);
         cnt  <= cnt - ONE;
      end
   end

   assign final_byte = (cnt == ONE);
endmodule

// File: rtl/cwdma_channel.sv
module cwdma_channel
   import cwdma_pkg::*;
#(
   parameter int AW   = 32,
   parameter int CNTW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] chain_ptr,
   output logic          busy,
   output logic          err,
   output logic          irq,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic [AW-1:0] bus_addr,
   output logic          bus_we,
   output logic          bus_word,
   output logic [7:0]    bus_wdata,
   input  logic [31:0]   bus_rdata,
   output logic          dev_out_valid,
   input  logic          dev_out_ready,
   output logic [7:0]    dev_out_data,
   output logic          dev_out_last,
   input  logic          dev_in_valid,
   output logic          dev_in_ready,
   input  logic [7:0]    dev_in_data,
   input  logic          dev_in_last,
   input  logic          dev_err
);
   localparam int SLOT_LAST = CW_SLOTS - 1;

   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("cwdma_channel: AW must lie in 8..32");
   end
   if (CNTW < 1 || CNTW > 32) begin : g_bad_cntw
      $error("cwdma_channel: CNTW must lie in 1..32");
   end

   cw_state_t       st;
   logic [1:0]      widx;
   logic [AW-1:0]   pc;
   logic [7:0]      data_q;
   logic            busy_q, err_q, irq_q;

   logic [FL_W-1:0] cw_flags;
   logic [AW-1:0]   cw_addr, cw_next, ctr_addr;
   logic [CNTW-1:0] cw_count, ctr_cnt;
   logic            ctr_final;
   logic            granted, cw_load, ctr_load, ctr_step;
   logic            blk_end;

   assign granted  = bus_req && bus_gnt;
   assign cw_load  = (st == ST_FETCH) && granted;
   assign ctr_load = (st == ST_FGAP) && (widx == 2'(SLOT_LAST));
   assign ctr_step = ((st == ST_DOUT) && dev_out_ready) ||
                     ((st == ST_MWR) && granted);
   assign blk_end  = ctr_final && cw_flags[FL_EOB];

   cwdma_cmd_reg #(.AW(AW), .CNTW(CNTW)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cw_load),
      .slot     (widx),
      .word     (bus_rdata),
      .flags    (cw_flags),
      .buf_addr (cw_addr),
      .count    (cw_count),
      .next_ptr (cw_next)
   );

   cwdma_block_ctr #(.AW(AW), .CNTW(CNTW)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (ctr_load),
      .addr_in    (cw_addr),
      .cnt_in     (cw_count),
      .step       (ctr_step),
      .addr       (ctr_addr),
      .cnt        (ctr_cnt),
      .final_byte (ctr_final)
   );

   always_comb begin
      bus_req  = 1'b0;
      bus_we   = 1'b0;
      bus_word = 1'b0;
      bus_addr = ctr_addr;
      unique case (st)
         ST_FETCH: begin
            bus_req  = 1'b1;
            bus_word = 1'b1;
            bus_addr = pc + (AW'(widx) << 2);
         end
         ST_MRD:  bus_req = 1'b1;
         ST_MWR: begin
            bus_req = 1'b1;
            bus_we  = 1'b1;
         end
         default: ;
      endcase
   end

   assign bus_wdata     = data_q;
   assign dev_out_valid = (st == ST_DOUT);
   assign dev_out_data  = data_q;
   assign dev_out_last  = (st == ST_DOUT) && blk_end;
   assign dev_in_ready  = (st == ST_DIN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         widx   <= '0;
         pc     <= '0;
         data_q <= '0;
         busy_q <= 1'b0;
         err_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (st != ST_IDLE && dev_err) begin
            st     <= ST_IDLE;
            busy_q <= 1'b0;
            err_q  <= 1'b1;
            irq_q  <= 1'b1;
         end else begin
            unique case (st)
               ST_IDLE: if (go) begin
                  pc     <= chain_ptr;
                  widx   <= '0;
                  st     <= ST_FETCH;
                  busy_q <= 1'b1;
                  err_q  <= 1'b0;
               end
               ST_FETCH: if (granted) st <= ST_FGAP;
               ST_FGAP: begin
                  if (widx != 2'(SLOT_LAST)) begin
                     widx <= widx + 2'd1;
                     st   <= ST_FETCH;
                  end else if (cw_count == '0) begin
                     st     <= ST_IDLE;
                     busy_q <= 1'b0;
                     err_q  <= 1'b1;
                     irq_q  <= 1'b1;
                  end else begin
                     st <= cw_flags[FL_TODEV] ? ST_MRD : ST_DIN;
                  end
               end
               ST_MRD: if (granted) begin
                  data_q <= bus_rdata[7:0];
                  st     <= ST_DOUT;
               end
               ST_DOUT: if (dev_out_ready)
                  st <= ctr_final ? ST_NEXT : ST_MRD;
               ST_DIN: if (dev_in_valid) begin
                  if (dev_in_last != blk_end) begin
                     st     <= ST_IDLE;
                     busy_q <= 1'b0;
                     err_q  <= 1'b1;
                     irq_q  <= 1'b1;
                  end else begin
                     data_q <= dev_in_data;
                     st     <= ST_MWR;
                  end
               end
               ST_MWR: if (granted)
                  st <= ctr_final ? ST_NEXT : ST_DIN;
               ST_NEXT: begin
                  if (cw_flags[FL_EOC]) begin
                     st     <= ST_IDLE;
                     busy_q <= 1'b0;
                     irq_q  <= 1'b1;
                  end else begin
                     pc   <= cw_next;
                     widx <= '0;
                     st   <= ST_FETCH;
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy = busy_q;
   assign err  = err_q;
   assign irq  = irq_q;

   logic unused_cnt;
   assign unused_cnt = ^ctr_cnt;
endmodule

// File: rtl/cwdma_channel_chk.sv
module cwdma_channel_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          go,
   input logic          busy,
   input logic          irq,
   input logic          bus_req,
   input logic          bus_gnt,
   input logic [AW-1:0] bus_addr,
   input logic          dev_out_valid,
   input logic          dev_out_ready,
   input logic [7:0]    dev_out_data,
   input logic          dev_err
);
   a_r1_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
      go && !busy |=> busy);

   a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_gnt |=> !bus_req);

   a_r3_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_gnt && !dev_err |=> bus_req && $stable(bus_addr));

   a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req);

   a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dev_out_valid && !dev_out_ready && !dev_err |=>
         dev_out_valid && $stable(dev_out_data));

   a_r11_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   a_r11_irq_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !busy && $past(busy));
endmodule

bind cwdma_channel cwdma_channel_chk #(.AW(AW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .go            (go),
   .busy          (busy),
   .irq           (irq),
   .bus_req       (bus_req),
   .bus_gnt       (bus_gnt),
   .bus_addr      (bus_addr),
   .dev_out_valid (dev_out_valid),
   .dev_out_ready (dev_out_ready),
   .dev_out_data  (dev_out_data),
   .dev_err       (dev_err)
);

// File: tb/tb_cwdma_channel.sv
`timescale 1ns/1ps
module tb_cwdma_channel;
   localparam int AW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          go = 1'b0;
   logic [AW-1:0] chain_ptr = '0;
   logic          busy, err, irq, bus_req, bus_we, bus_word;
   logic          bus_gnt;
   logic [AW-1:0] bus_addr;
   logic [7:0]    bus_wdata;
   logic [31:0]   bus_rdata;
   logic          dev_out_valid, dev_out_ready, dev_out_last;
   logic [7:0]    dev_out_data;
   logic          dev_in_valid, dev_in_ready, dev_in_last;
   logic [7:0]    dev_in_data;
   logic          dev_err = 1'b0;

   cwdma_channel #(.AW(AW), .CNTW(16)) dut (
      .clk(clk), .rst_n(rst_n), .go(go), .chain_ptr(chain_ptr),
      .busy(busy), .err(err), .irq(irq),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_word(bus_word), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready),
      .dev_out_data(dev_out_data), .dev_out_last(dev_out_last),
      .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
      .dev_in_data(dev_in_data), .dev_in_last(dev_in_last),
      .dev_err(dev_err)
   );

   int unsigned n_chk = 0, n_fail = 0;
   int unsigned cyc = 0;
   bit done_flag = 0;

   logic [7:0] mem [0:4095];
   logic [11:0] ma;
   assign ma = bus_addr[11:0];
   assign bus_rdata = {mem[ma + 12'd3], mem[ma + 12'd2], mem[ma + 12'd1], mem[ma]};
   assign bus_gnt = (cyc % 4) != 0;
   assign dev_out_ready = (cyc % 3) != 2;

   logic [7:0] out_buf [0:255];
   logic       out_lst [0:255];
   int unsigned out_n = 0;
   int unsigned irq_n = 0;
   int unsigned r3_bad = 0;
   logic        prev_grant = 1'b0;

   logic [7:0] in_bytes [0:63];
   logic       in_last  [0:63];
   int unsigned in_idx = 0, in_len = 0;
   assign dev_in_valid = (in_idx < in_len) && ((cyc % 3) != 1);
   assign dev_in_data  = in_bytes[in_idx[5:0]];
   assign dev_in_last  = in_last[in_idx[5:0]];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         if (bus_req && bus_gnt && bus_we) mem[ma] <= bus_wdata;
         if (dev_out_valid && dev_out_ready) begin
            out_buf[out_n[7:0]] <= dev_out_data;
            out_lst[out_n[7:0]] <= dev_out_last;
            out_n <= out_n + 1;
         end
         if (dev_in_valid && dev_in_ready) in_idx <= in_idx + 1;
         if (irq) irq_n <= irq_n + 1;
         if (prev_grant && bus_req) r3_bad <= r3_bad + 1;
         if (bus_req && !busy) r3_bad <= r3_bad + 1;
         prev_grant <= bus_req && bus_gnt;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
   end

   task automatic put_w(input int a, input logic [31:0] v);
      for (int b = 0; b < 4; b++) mem[a + b] = v[8*b +: 8];
   endtask

   task automatic put_cw(input int at, input int fl, input int ad, input int cn, input int nx);
      put_w(at, 32'(fl)); put_w(at + 4, 32'(ad));
      put_w(at + 8, 32'(cn)); put_w(at + 12, 32'(nx));
   endtask

   task automatic start(input int p);
      @(negedge clk);
      chain_ptr = 32'(p); go = 1'b1;
      @(negedge clk);
      go = 1'b0;
   endtask

   task automatic wait_irq(input int base_irq);
      for (int t = 0; t < 3000 && irq_n == base_irq; t++) @(negedge clk);
      @(negedge clk);
   endtask

   int base_o, base_i, mism, lmism, tot, k;
   int cnts [3];
   int bufs [3];
   int fls  [3];

   initial begin
      for (int a = 0; a < 4096; a++) mem[a] = 8'hEE;
      for (int a = 0; a < 64; a++) begin in_bytes[a] = 8'h00; in_last[a] = 1'b0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !err && !irq && !bus_req && !dev_out_valid && !dev_in_ready,
          "R1 reset idle", {busy, err, irq, bus_req}, 0);

      // R9: zero-count word stops with error, nothing moves
      put_cw(12'h080, 5, 12'h600, 0, 0);
      base_o = out_n; base_i = irq_n;
      start(12'h080);
      chk(busy == 1'b1, "R1 busy after go", busy, 1);
      wait_irq(base_i);
      chk(err == 1'b1 && !busy, "R9 zero count error", err, 1);
      chk(out_n == base_o, "R9 no bytes moved", out_n - base_o, 0);
      chk(irq_n == base_i + 1, "R11 one irq on error", irq_n - base_i, 1);

      // R10: device error strobe mid-transfer
      for (int a = 0; a < 20; a++) mem[12'h700 + a] = 8'(a + 1);
      put_cw(12'h0C0, 7, 12'h700, 20, 0);
      base_o = out_n; base_i = irq_n;
      start(12'h0C0);
      for (int t = 0; t < 500 && out_n < base_o + 3; t++) @(negedge clk);
      dev_err = 1'b1;
      @(negedge clk);
      dev_err = 1'b0;
      wait_irq(base_i);
      chk(err && !busy, "R10 device error stops chain", err, 1);
      chk(out_n - base_o < 20, "R10 transfer cut short", out_n - base_o, 4);

      // R8: device marks block end early
      for (int a = 0; a < 6; a++) mem[12'h780 + a] = 8'hEE;
      put_cw(12'h0E0, 2 | 4, 12'h780, 4, 0);
      in_bytes[0] = 8'hA1; in_bytes[1] = 8'hA2; in_bytes[2] = 8'hA3; in_bytes[3] = 8'hA4;
      in_last[0] = 1'b0; in_last[1] = 1'b1; in_last[2] = 1'b0; in_last[3] = 1'b1;
      @(negedge clk); in_idx = 0; in_len = 4;
      base_i = irq_n;
      start(12'h0E0);
      wait_irq(base_i);
      chk(err == 1'b1, "R8 early last flagged", err, 1);
      chk(mem[12'h780] == 8'hA1 && mem[12'h781] == 8'hEE, "R8 mismatched byte not written",
          mem[12'h781], 8'hEE);
      @(negedge clk); in_len = 0; in_idx = 0;

      // R1: go while busy ignored
      put_cw(12'h040, 5, 12'h600, 0, 0);
      for (int a = 0; a < 8; a++) mem[12'h740 + a] = 8'(8'h30 + a);
      put_cw(12'h0F0, 1 | 2 | 4, 12'h740, 8, 0);
      base_o = out_n; base_i = irq_n;
      start(12'h0F0);
      repeat (4) @(negedge clk);
      start(12'h040);
      wait_irq(base_i);
      repeat (4) @(negedge clk);
      chk(!err && irq_n == base_i + 1, "R1 second go ignored", irq_n - base_i, 1);
      mism = 0;
      for (int j = 0; j < 8; j++) if (out_buf[base_o + j] != 8'(8'h30 + j)) mism++;
      chk(out_n == base_o + 8 && mism == 0, "R1 chain unaffected by go", mism, 0);

      // Sweep: chain length x count base x direction
      for (int dir = 0; dir < 2; dir++)
      for (int nw = 1; nw <= 3; nw++)
      for (int bc = 1; bc <= 3; bc++) begin
         tot = 0;
         for (int i = 0; i < nw; i++) begin
            cnts[i] = ((bc + i) % 3) + 1 + i;
            bufs[i] = 12'h400 + 12'h40 * (nw - i) + bc;
            fls[i]  = dir | ((i == nw - 1 || (nw == 3 && i == 0)) ? 2 : 0) |
                      ((i == nw - 1) ? 4 : 0);
            put_cw(12'h100 + 12'h30 * (2 - i) + 12'h200 * 0, fls[i], bufs[i], cnts[i],
                   12'h100 + 12'h30 * (1 - i));
            for (int a = -1; a <= cnts[i]; a++)
               mem[bufs[i] + a] = dir ? 8'((bufs[i] + a) * 7 + nw) : 8'hEE;
            tot += cnts[i];
         end
         k = 0;
         for (int i = 0; i < nw; i++)
            for (int j = 0; j < cnts[i]; j++) begin
               in_bytes[k] = 8'(k * 13 + bc * 5 + nw);
               in_last[k]  = (j == cnts[i] - 1) && fls[i][1];
               k++;
            end
         @(negedge clk);
         in_idx = 0; in_len = dir ? 0 : tot;
         base_o = out_n; base_i = irq_n;
         start(12'h100 + 12'h60);
         wait_irq(base_i);
         chk(!err && !busy && irq_n == base_i + 1, "R11 clean finish single irq",
             irq_n - base_i, 1);
         mism = 0; lmism = 0; k = 0;
         if (dir) begin
            for (int i = 0; i < nw; i++)
               for (int j = 0; j < cnts[i]; j++) begin
                  if (out_buf[base_o + k] != 8'((bufs[i] + j) * 7 + nw)) mism++;
                  if (out_lst[base_o + k] != ((j == cnts[i] - 1) && fls[i][1])) lmism++;
                  k++;
               end
            chk(out_n - base_o == tot, "R6 R4 byte count over chain", out_n - base_o, tot);
            chk(mism == 0, "R4 R2 gathered bytes in order", mism, 0);
            chk(lmism == 0, "R7 block end marker", lmism, 0);
         end else begin
            for (int i = 0; i < nw; i++) begin
               for (int j = 0; j < cnts[i]; j++) begin
                  if (mem[bufs[i] + j] != in_bytes[k]) mism++;
                  k++;
               end
               if (mem[bufs[i] + cnts[i]] != 8'hEE || mem[bufs[i] - 1] != 8'hEE) lmism++;
            end
            chk(in_idx == tot, "R6 R8 device bytes consumed", in_idx, tot);
            chk(mism == 0, "R5 scattered bytes stored", mism, 0);
            chk(lmism == 0, "R5 guard bytes untouched", lmism, 0);
         end
      end
      @(negedge clk); in_len = 0;
      chk(r3_bad == 0, "R3 request released after grant", r3_bad, 0);
      finish_run();
   end
endmodule